// File: doc/BRIEF.md
# Virtual-Screen Scan Address Generator

This block produces the half-word read addresses that a display refresh engine uses to fetch pixels from a frame buffer. The displayed panel is a window into a wider virtual screen. Each displayed line covers a programmable number of half-words (the page width). Between the end of one displayed line and the start of the next, the address skips a programmable number of half-words (the line skip). Moving the base address therefore scrolls the panel across the larger image, and the memory that is not shown is never fetched.

The refresh engine pulses `pixReq` once for every half-word it wants and `lineAdv` once at the end of every line. The address has two parts. A 21-bit half-word field increments and wraps. A 7-bit bank field stays fixed for the whole frame and sits above it. After the configured number of lines the generator pulses `frameDone`, returns to the base address and takes a fresh copy of the configuration. This lets software rewrite the scroll position at any time without tearing the picture. The block also reports the frame end address and reorders the byte and half-word lanes of the 32-bit words returned from memory.

Top module: `vscan_addr_gen`

## Requirements
- R1: While `rstN` is low, `memAddr` is 0 and `frameDone` is 0. On the first rising clock edge after `rstN` goes high, the generator captures the configuration and `memAddr` becomes `{cfgBank, cfgBase}`. `frameDone` does not pulse on this capture.
- R2: Each accepted `pixReq` adds one to the half-word field `memAddr[20:0]` and leaves the bank field `memAddr[27:21]` unchanged.
- R3: On any one line, at most page-width pixel requests are accepted. Once a line has taken that many, further `pixReq` pulses are ignored and the address holds at line start plus page width.
- R4: A `lineAdv` that does not end the frame sets the address to the previous line start plus page width plus line skip. This holds however many pixel requests the line received. The pixel count for the new line starts from zero.
- R5: The `lineAdv` pulse numbered `cfgLineLast`+1 in a frame ends the frame. After that clock edge, `frameDone` is high for exactly one cycle and `memAddr` equals `{cfgBank, cfgBase}` as sampled at that edge. A `pixReq` arriving at the same edge is ignored.
- R6: `frameEnd` equals base + (page width + line skip) × (line count + 1), taken modulo 2^21. Its operands are the values captured for the current frame.
- R7: Changes to `cfgBase`, `cfgBank`, `cfgPageWidth`, `cfgOffset` and `cfgLineLast` during a frame do not affect `memAddr` or `frameEnd` until the next frame starts.
- R8: `swapData` is `rdData` with its lanes reordered, and the two swap controls act at once. `cfgByteSwap` exchanges the two bytes inside each half-word. `cfgHwSwap` exchanges the upper and lower half-words. With both set, the four bytes come out fully reversed.
- R9: The half-word field wraps from 2^21−1 to 0 with no carry into the bank field.
- R10: In a cycle with neither `pixReq` nor `lineAdv`, `memAddr` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | 21 | Frame start address in half-words (byte address bits 21:1) |
| cfgBank | input | 7 | Bank bits placed above the half-word field (byte address bits 28:22) |
| cfgPageWidth | input | 11 | Half-words shown per line |
| cfgOffset | input | 11 | Half-words skipped between lines |
| cfgLineLast | input | 10 | Lines per frame minus one |
| cfgHwSwap | input | 1 | Swap the two half-words of the read data |
| cfgByteSwap | input | 1 | Swap the bytes within each half-word of the read data |
| pixReq | input | 1 | Request for the next half-word of the line |
| lineAdv | input | 1 | End-of-line strobe |
| rdData | input | 32 | Word returned from memory |
| memAddr | output | 28 | Read address {bank, half-word}, byte address bits 28:1 |
| swapData | output | 32 | Lane-reordered read data |
| frameEnd | output | 21 | Computed frame end address in half-words |
| frameDone | output | 1 | One-cycle pulse after the last line of a frame |

## Verification
The scan is driven with a short line that gets exactly its page width of requests, then with an over-long burst, then with a line cut short before its width is reached. These patterns separate a generator that clamps at the page width and jumps from the line start from one that simply adds the skip to the current pointer. A configuration rewrite in the middle of a frame, followed by a frame end that coincides with a pixel request, tells per-frame capture apart from live use of the inputs. A one-line frame placed at the top of the half-word range checks the wrap and the bank isolation. A table of data words covers all four lane orders, using words whose bytes are all different.

// File: rtl/vscan_pkg.sv
`timescale 1ns/1ps
package vscan_pkg;
  // Strobes from the scan control to the address datapath; at most one is set.
  typedef struct packed {
    logic load;     // capture configuration and restart at the base
    logic step;     // advance one half-word
    logic nextLine; // jump to the start of the next line
  } scanStrobes_t;
endpackage

// File: rtl/vscan_lane_swap.sv
`timescale 1ns/1ps
module vscan_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rdData,
  input  logic              hwSwap,
  input  logic              byteSwap,
  output logic [DATA_W-1:0] swapData
);
  localparam int HALVES = DATA_W / 16;

  logic [DATA_W-1:0] byteStage;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    // byte exchange inside half-word h
    assign byteStage[16*h +: 16] = byteSwap ?
      {rdData[16*h +: 8], rdData[16*h+8 +: 8]} : rdData[16*h +: 16];
    // half-word order reversal across the word
    assign swapData[16*h +: 16] = hwSwap ?
      byteStage[16*(HALVES-1-h) +: 16] : byteStage[16*h +: 16];
  end
endmodule

// File: rtl/vscan_ctrl.sv
`timescale 1ns/1ps
module vscan_ctrl
  import vscan_pkg::*;
#(
  parameter int PW_W   = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PW_W-1:0]   cfgPageWidth,
  input  logic [LINE_W-1:0] cfgLineLast,
  input  logic              pixReq,
  input  logic              lineAdv,
  output scanStrobes_t      strobes,
  output logic [PW_W-1:0]   curPageWidth,
  output logic [LINE_W-1:0] curLineLast,
  output logic              frameDone
);
  logic              loadPending;
  logic [PW_W-1:0]   pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic              lastLine;
  logic              wrap;
  logic              lineFull;

  assign lastLine = (lineCnt == curLineLast);
  assign wrap     = lineAdv && !loadPending && lastLine;
  assign lineFull = (pixCnt == curPageWidth);

  always_comb begin
    strobes          = '0;
    strobes.load     = loadPending || wrap;
    strobes.nextLine = lineAdv && !strobes.load;
    strobes.step     = pixReq && !lineAdv && !strobes.load && !lineFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPending  <= 1'b1;
      pixCnt       <= '0;
      lineCnt      <= '0;
      curPageWidth <= '0;
      curLineLast  <= '0;
      frameDone    <= 1'b0;
    end else begin
      frameDone <= wrap;
      if (strobes.load) begin
        loadPending  <= 1'b0;
        pixCnt       <= '0;
        lineCnt      <= '0;
        curPageWidth <= cfgPageWidth;
        curLineLast  <= cfgLineLast;
      end else if (strobes.nextLine) begin
        pixCnt  <= '0;
        lineCnt <= lineCnt + 1'b1;
      end else if (strobes.step) begin
        pixCnt <= pixCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vscan_datapath.sv
`timescale 1ns/1ps
module vscan_datapath
  import vscan_pkg::*;
#(
  parameter int HW_W   = 21,
  parameter int BANK_W = 7,
  parameter int PW_W   = 11,
  parameter int OFF_W  = 11,
  parameter int LINE_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanStrobes_t           strobes,
  input  logic [HW_W-1:0]        cfgBase,
  input  logic [BANK_W-1:0]      cfgBank,
  input  logic [OFF_W-1:0]       cfgOffset,
  input  logic [PW_W-1:0]        curPageWidth,
  input  logic [LINE_W-1:0]      curLineLast,
  input  logic [DATA_W-1:0]      rdData,
  input  logic                   cfgHwSwap,
  input  logic                   cfgByteSwap,
  output logic [BANK_W+HW_W-1:0] memAddr,
  output logic [HW_W-1:0]        frameEnd,
  output logic [DATA_W-1:0]      swapData
);
  localparam int SUM_W  = ((PW_W > OFF_W) ? PW_W : OFF_W) + 1;
  localparam int CNT_W  = LINE_W + 1;
  localparam int PROD_W = SUM_W + CNT_W;

  logic [HW_W-1:0]   baseQ;
  logic [BANK_W-1:0] bankQ;
  logic [OFF_W-1:0]  offsetQ;
  logic [HW_W-1:0]   lineStart;
  logic [HW_W-1:0]   hwPtr;
  logic [SUM_W-1:0]  lineSpan;
  logic [CNT_W-1:0]  lineTotal;
  logic [PROD_W-1:0] frameSpan;
  logic [HW_W-1:0]   nextStart;

  assign lineSpan  = SUM_W'(curPageWidth) + SUM_W'(offsetQ);
  assign lineTotal = CNT_W'(curLineLast) + CNT_W'(1);
  assign frameSpan = PROD_W'(lineSpan) * PROD_W'(lineTotal);
  assign frameEnd  = baseQ + HW_W'(frameSpan);
  assign nextStart = lineStart + HW_W'(lineSpan);
  assign memAddr   = {bankQ, hwPtr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      bankQ     <= '0;
      offsetQ   <= '0;
      lineStart <= '0;
      hwPtr     <= '0;
    end else if (strobes.load) begin
      baseQ     <= cfgBase;
      bankQ     <= cfgBank;
      offsetQ   <= cfgOffset;
      lineStart <= cfgBase;
      hwPtr     <= cfgBase;
    end else if (strobes.nextLine) begin
      lineStart <= nextStart;
      hwPtr     <= nextStart;
    end else if (strobes.step) begin
      hwPtr <= hwPtr + HW_W'(1);
    end
  end

  vscan_lane_swap #(.DATA_W(DATA_W)) u_swap (
    .rdData   (rdData),
    .hwSwap   (cfgHwSwap),
    .byteSwap (cfgByteSwap),
    .swapData (swapData)
  );
endmodule

// File: rtl/vscan_addr_gen.sv
`timescale 1ns/1ps
module vscan_addr_gen
  import vscan_pkg::*;
#(
  parameter int HW_W   = 21,
  parameter int BANK_W = 7,
  parameter int PW_W   = 11,
  parameter int OFF_W  = 11,
  parameter int LINE_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [HW_W-1:0]        cfgBase,
  input  logic [BANK_W-1:0]      cfgBank,
  input  logic [PW_W-1:0]        cfgPageWidth,
  input  logic [OFF_W-1:0]       cfgOffset,
  input  logic [LINE_W-1:0]      cfgLineLast,
  input  logic                   cfgHwSwap,
  input  logic                   cfgByteSwap,
  input  logic                   pixReq,
  input  logic                   lineAdv,
  input  logic [DATA_W-1:0]      rdData,
  output logic [BANK_W+HW_W-1:0] memAddr,
  output logic [DATA_W-1:0]      swapData,
  output logic [HW_W-1:0]        frameEnd,
  output logic                   frameDone
);
  scanStrobes_t      strobes;
  logic [PW_W-1:0]   curPageWidth;
  logic [LINE_W-1:0] curLineLast;

  vscan_ctrl #(.PW_W(PW_W), .LINE_W(LINE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgPageWidth (cfgPageWidth),
    .cfgLineLast  (cfgLineLast),
    .pixReq       (pixReq),
    .lineAdv      (lineAdv),
    .strobes      (strobes),
    .curPageWidth (curPageWidth),
    .curLineLast  (curLineLast),
    .frameDone    (frameDone)
  );

  vscan_datapath #(
    .HW_W(HW_W), .BANK_W(BANK_W), .PW_W(PW_W),
    .OFF_W(OFF_W), .LINE_W(LINE_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgBase      (cfgBase),
    .cfgBank      (cfgBank),
    .cfgOffset    (cfgOffset),
    .curPageWidth (curPageWidth),
    .curLineLast  (curLineLast),
    .rdData       (rdData),
    .cfgHwSwap    (cfgHwSwap),
    .cfgByteSwap  (cfgByteSwap),
    .memAddr      (memAddr),
    .frameEnd     (frameEnd),
    .swapData     (swapData)
  );
endmodule

// File: rtl/vscan_checker.sv
`timescale 1ns/1ps
module vscan_checker
  import vscan_pkg::*;
#(
  parameter int HW_W   = 21,
  parameter int BANK_W = 7
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pixReq,
  input logic                   lineAdv,
  input logic [HW_W-1:0]        cfgBase,
  input scanStrobes_t           strobes,
  input logic [BANK_W+HW_W-1:0] memAddr,
  input logic                   frameDone
);
  localparam int ADDR_W = BANK_W + HW_W;

  // R2, R9: an accepted request moves the half-word field by exactly one
  assert_step_plus_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (memAddr[HW_W-1:0] == $past(memAddr[HW_W-1:0]) + HW_W'(1)));

  // R9: outside a frame capture the bank field never changes
  assert_bank_fixed_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(memAddr[ADDR_W-1:HW_W]));

  // R10: no strobe in, no address movement
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!pixReq && !lineAdv && !strobes.load) |=> $stable(memAddr));

  // R5: a frame-done pulse follows a line advance and lands on the captured base
  assert_done_after_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(lineAdv));

  assert_done_at_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (memAddr[HW_W-1:0] == $past(cfgBase)));

  // R3, R4: control never issues two datapath actions together
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step, strobes.nextLine}));
endmodule

bind vscan_addr_gen vscan_checker #(.HW_W(HW_W), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pixReq    (pixReq),
  .lineAdv   (lineAdv),
  .cfgBase   (cfgBase),
  .strobes   (strobes),
  .memAddr   (memAddr),
  .frameDone (frameDone)
);

// File: tb/tb_vscan_addr_gen.sv
`timescale 1ns/1ps
module tb_vscan_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] cfgBase = '0;
  logic [6:0]  cfgBank = '0;
  logic [10:0] cfgPageWidth = '0;
  logic [10:0] cfgOffset = '0;
  logic [9:0]  cfgLineLast = '0;
  logic        cfgHwSwap = 1'b0;
  logic        cfgByteSwap = 1'b0;
  logic        pixReq = 1'b0;
  logic        lineAdv = 1'b0;
  logic [31:0] rdData = '0;
  logic [27:0] memAddr;
  logic [31:0] swapData;
  logic [20:0] frameEnd;
  logic        frameDone;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  vscan_addr_gen dut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgBank(cfgBank),
    .cfgPageWidth(cfgPageWidth), .cfgOffset(cfgOffset), .cfgLineLast(cfgLineLast),
    .cfgHwSwap(cfgHwSwap), .cfgByteSwap(cfgByteSwap), .pixReq(pixReq),
    .lineAdv(lineAdv), .rdData(rdData), .memAddr(memAddr), .swapData(swapData),
    .frameEnd(frameEnd), .frameDone(frameDone)
  );

  // {data, hwSwap, byteSwap, expected}
  localparam logic [65:0] SWAP_TAB [8] = '{
    {32'h11223344, 1'b0, 1'b0, 32'h11223344},
    {32'h11223344, 1'b1, 1'b0, 32'h33441122},
    {32'h11223344, 1'b0, 1'b1, 32'h22114433},
    {32'h11223344, 1'b1, 1'b1, 32'h44332211},
    {32'hA1B2C3D4, 1'b0, 1'b0, 32'hA1B2C3D4},
    {32'hA1B2C3D4, 1'b1, 1'b0, 32'hC3D4A1B2},
    {32'hA1B2C3D4, 1'b0, 1'b1, 32'hB2A1D4C3},
    {32'hA1B2C3D4, 1'b1, 1'b1, 32'hD4C3B2A1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; applies strobes for one rising edge, returns at the next negedge
  task automatic pulse(input logic p, input logic l);
    pixReq = p;
    lineAdv = l;
    @(negedge clk);
    pixReq = 1'b0;
    lineAdv = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: lane reordering table
    for (int i = 0; i < 8; i++) begin
      rdData      = SWAP_TAB[i][65:34];
      cfgHwSwap   = SWAP_TAB[i][33];
      cfgByteSwap = SWAP_TAB[i][32];
      #1;
      check("R8 lane swap", swapData, SWAP_TAB[i][31:0]);
    end

    cfgBase = 21'h000100; cfgBank = 7'h05; cfgPageWidth = 11'd4;
    cfgOffset = 11'd3; cfgLineLast = 10'd2;
    repeat (3) @(negedge clk);
    check("R1 reset addr", {4'h0, memAddr}, 32'h0);
    check("R1 reset done", {31'h0, frameDone}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first capture", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000100});
    check("R1 no done on capture", {31'h0, frameDone}, 32'h0);
    check("R6 frame end", {11'h0, frameEnd}, 32'h115);

    pulse(1, 0); pulse(1, 0);
    check("R2 two steps", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000102});
    repeat (3) pulse(1, 0);
    check("R3 clamp at width", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000104});
    repeat (3) @(negedge clk);
    check("R10 idle hold", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000104});
    pulse(0, 1);
    check("R4 full line skip", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000107});
    pulse(1, 0);
    pulse(0, 1);
    check("R4 short line skip", {4'h0, memAddr}, {4'h0, 7'h05, 21'h00010E});

    // R7: rewrite configuration mid-frame
    cfgBase = 21'h000200; cfgBank = 7'h06; cfgPageWidth = 11'd2;
    cfgOffset = 11'd1; cfgLineLast = 10'd0;
    @(negedge clk);
    check("R7 addr unchanged", {4'h0, memAddr}, {4'h0, 7'h05, 21'h00010E});
    check("R7 end unchanged", {11'h0, frameEnd}, 32'h115);
    repeat (5) pulse(1, 0);
    check("R7 old width kept", {4'h0, memAddr}, {4'h0, 7'h05, 21'h000112});
    check("R5 no early done", {31'h0, frameDone}, 32'h0);

    pulse(1, 1);
    check("R5 done pulse", {31'h0, frameDone}, 32'h1);
    check("R5 reload base", {4'h0, memAddr}, {4'h0, 7'h06, 21'h000200});
    check("R6 new frame end", {11'h0, frameEnd}, 32'h203);
    @(negedge clk);
    check("R5 done one cycle", {31'h0, frameDone}, 32'h0);

    // one-line frame at the top of the half-word range
    cfgBase = 21'h1FFFFE; cfgBank = 7'h7F; cfgPageWidth = 11'd4;
    cfgOffset = 11'd0; cfgLineLast = 10'd0;
    pulse(1, 1);
    check("R5 single-line wrap done", {31'h0, frameDone}, 32'h1);
    check("R5 request ignored at wrap", {4'h0, memAddr}, {4'h0, 7'h7F, 21'h1FFFFE});
    check("R6 end modulo", {11'h0, frameEnd}, 32'h000002);
    repeat (3) pulse(1, 0);
    check("R9 field wrap", {4'h0, memAddr}, {4'h0, 7'h7F, 21'h000001});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule